// File: doc/BRIEF.md
# Word-Rate Timing Generator with Rotatable Low-Speed Clock

This block sits beside a configurable serializer/deserializer and derives all of its word-rate timing from the high-speed bit clock. It emits a one-cycle word strobe once per word, and the serializer uses it to load or unload its parallel register. The word length in high-speed cycles is chosen from eight fixed ratios.

It also produces a low-speed clock for downstream logic. That clock runs at the word rate, or at half the word rate when the halving control is set. Its position within its own period can be shifted in eighth-period steps to make up for board delays. For the ratios 5 and 10 no rotation is applied.

Configuration inputs are sampled during reset and then only on the first cycle of each low-speed period. A change made part way through a period therefore never cuts a period short. Both outputs are registered, so neither carries decode glitches.

Top module: `word_timing_gen`

## Requirements
- R1: While rstN is low at a rising clock edge, both wordStrobe and lsClk are low in the following cycle. The period counter restarts at zero, and the configuration inputs are captured.
- R2: ratioSel selects the word length R in high-speed cycles: code 0 gives 4, 1 gives 5, 2 gives 8, 3 gives 10, 4 gives 16, 5 gives 20, 6 gives 32 and 7 gives 40.
- R3: Counting the first rising edge after reset release as cycle 1, wordStrobe is high for exactly one cycle in each cycle n where n is a nonzero multiple of R, and low otherwise. Two strobes are never in adjacent cycles and never more than 40 cycles apart.
- R4: The low-speed clock period P is R when divHalf is 0 and 2R when divHalf is 1. In the halved case wordStrobe still fires every R cycles, twice per low-speed period.
- R5: Within each period, lsClk is high for floor(P/2) consecutive cycles starting at the phase-offset position, and low for the remaining cycles. With zero offset, cycle n is high when (n mod P) < floor(P/2).
- R6: phaseSel value k sets the offset to floor(k*P/8) cycles. This means lsClk in cycle n is high when ((n - offset) mod P) < floor(P/2).
- R7: When R is 5 or 10 (ratioSel codes 1 and 3), phaseSel is ignored and the offset is zero, with or without divHalf.
- R8: A change of ratioSel, divHalf or phaseSel after reset takes effect only from the first cycle of the next low-speed period. That cycle still carries the strobe that ends the old word, and timing then restarts from position zero with the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed bit clock |
| rstN | input | 1 | Synchronous reset, active low |
| ratioSel | input | 3 | Word-length code (R2) |
| divHalf | input | 1 | Halve the low-speed clock rate when high |
| phaseSel | input | 3 | Low-speed clock rotation in eighth-period steps |
| wordStrobe | output | 1 | One-cycle strobe per word |
| lsClk | output | 1 | Low-speed clock output |

## Verification
The word strobe and an edge of the low-speed clock share a cycle whenever the rotated high phase starts or ends on a word boundary. A period boundary also coincides with the strobe that ends the last word. The bench provokes both coincidences by walking every ratio code with offsets that land edges on and off word ends. It also changes the ratio and the phase part way through a period. In every cycle, each output is judged separately against the period, offset and strobe positions computed from the requirements. This shows that applying a new setting at the boundary neither drops nor duplicates the strobe.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
  localparam int MAX_RATIO = 40;
  localparam int CNT_W = $clog2(2 * MAX_RATIO);
  localparam int PH_W = 3;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic wordEnd;
    logic [CNT_W-1:0] nextPos;
    logic [CNT_W-1:0] period;
    logic rotateOk;
    logic [PH_W-1:0] phase;
  } tick_t;

  function automatic logic [CNT_W-1:0] ratioOf(input logic [SEL_W-1:0] sel);
    logic [CNT_W-1:0] r;
    case (sel)
      3'd0: r = CNT_W'(4);
      3'd1: r = CNT_W'(5);
      3'd2: r = CNT_W'(8);
      3'd3: r = CNT_W'(10);
      3'd4: r = CNT_W'(16);
      3'd5: r = CNT_W'(20);
      3'd6: r = CNT_W'(32);
      default: r = CNT_W'(40);
    endcase
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] periodOf(input logic [SEL_W-1:0] sel, input logic half);
    return half ? (ratioOf(sel) << 1) : ratioOf(sel);
  endfunction

  function automatic logic rotateAllowed(input logic [SEL_W-1:0] sel);
    return !(sel == 3'd1 || sel == 3'd3);
  endfunction
endpackage

// File: rtl/tgen_ctrl.sv
module tgen_ctrl
  import tgen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] ratioSel,
  input  logic             divHalf,
  input  logic [PH_W-1:0]  phaseSel,
  output tick_t            tick
);
  logic [SEL_W-1:0] cfgSel, nextSel;
  logic             cfgDiv, nextDiv;
  logic [PH_W-1:0]  cfgPh, nextPh;
  logic [CNT_W-1:0] pos, nextPos, curR, curP;
  logic             periodEnd;

  always_comb begin
    curR = ratioOf(cfgSel);
    curP = periodOf(cfgSel, cfgDiv);
    periodEnd = (pos == curP - CNT_W'(1));
    nextPos = periodEnd ? '0 : pos + CNT_W'(1);
    nextSel = periodEnd ? ratioSel : cfgSel;
    nextDiv = periodEnd ? divHalf : cfgDiv;
    nextPh = periodEnd ? phaseSel : cfgPh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgSel <= ratioSel;
      cfgDiv <= divHalf;
      cfgPh <= phaseSel;
      pos <= '0;
    end else begin
      cfgSel <= nextSel;
      cfgDiv <= nextDiv;
      cfgPh <= nextPh;
      pos <= nextPos;
    end
  end

  always_comb begin
    tick.wordEnd = (pos == curR - CNT_W'(1)) || periodEnd;
    tick.nextPos = nextPos;
    tick.period = periodOf(nextSel, nextDiv);
    tick.rotateOk = rotateAllowed(nextSel);
    tick.phase = nextPh;
  end
endmodule

// File: rtl/tgen_dp.sv
module tgen_dp
  import tgen_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  tick_t tick,
  output logic  wordStrobe,
  output logic  lsClk
);
  localparam int PW = PH_W + CNT_W;

  logic [PW-1:0]    prod;
  logic [CNT_W-1:0] offset;
  logic [CNT_W:0]   relPos;
  logic             highNext;

  always_comb begin
    prod = PW'(tick.phase) * PW'(tick.period);
    offset = tick.rotateOk ? prod[PW-1:PH_W] : '0;
    if (tick.nextPos >= offset)
      relPos = {1'b0, tick.nextPos} - {1'b0, offset};
    else
      relPos = {1'b0, tick.nextPos} + {1'b0, tick.period} - {1'b0, offset};
    highNext = relPos < {1'b0, tick.period >> 1};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordStrobe <= 1'b0;
      lsClk <= 1'b0;
    end else begin
      wordStrobe <= tick.wordEnd;
      lsClk <= highNext;
    end
  end
endmodule

// File: rtl/word_timing_gen.sv
module word_timing_gen
  import tgen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] ratioSel,
  input  logic       divHalf,
  input  logic [2:0] phaseSel,
  output logic       wordStrobe,
  output logic       lsClk
);
  tick_t tick;

  tgen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ratioSel(ratioSel),
    .divHalf(divHalf), .phaseSel(phaseSel), .tick(tick)
  );

  tgen_dp u_dp (
    .clk(clk), .rstN(rstN), .tick(tick),
    .wordStrobe(wordStrobe), .lsClk(lsClk)
  );
endmodule

// File: rtl/word_timing_gen_chk.sv
module word_timing_gen_chk (
  input logic clk,
  input logic rstN,
  input logic wordStrobe,
  input logic lsClk
);
  logic       inRstQ = 1'b0;
  logic [7:0] gapCnt = 8'd0;
  logic       gapLegal;

  always_ff @(posedge clk) begin
    inRstQ <= !rstN;
    if (!rstN) gapCnt <= 8'd0;
    else if (wordStrobe) gapCnt <= 8'd1;
    else if (gapCnt != 8'hFF) gapCnt <= gapCnt + 8'd1;
  end

  always_comb begin
    case (gapCnt)
      8'd4, 8'd5, 8'd8, 8'd10, 8'd16, 8'd20, 8'd32, 8'd40: gapLegal = 1'b1;
      default: gapLegal = 1'b0;
    endcase
  end

  // R1
  always_comb begin
    if (inRstQ) reset_quiet_chk: assert (!wordStrobe && !lsClk);
  end

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordStrobe |=> !wordStrobe);

  // R2
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordStrobe |-> gapLegal);

  // R3
  strobe_starved_chk: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt <= 8'd40);
endmodule

bind word_timing_gen word_timing_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .wordStrobe(wordStrobe), .lsClk(lsClk)
);

// File: tb/word_timing_gen_tb.sv
module word_timing_gen_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0] sel;
    logic       dh;
    logic [2:0] ph;
    logic [7:0] r;
    logic [7:0] p;
    logic [7:0] off;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 3'd3, 8'd4,  8'd4,  8'd1},
    '{3'd1, 1'b0, 3'd5, 8'd5,  8'd5,  8'd0},
    '{3'd2, 1'b1, 3'd3, 8'd8,  8'd16, 8'd6},
    '{3'd3, 1'b1, 3'd7, 8'd10, 8'd20, 8'd0},
    '{3'd4, 1'b0, 3'd7, 8'd16, 8'd16, 8'd14},
    '{3'd5, 1'b1, 3'd1, 8'd20, 8'd40, 8'd5},
    '{3'd6, 1'b0, 3'd4, 8'd32, 8'd32, 8'd16},
    '{3'd7, 1'b1, 3'd6, 8'd40, 8'd80, 8'd60},
    '{3'd0, 1'b1, 3'd2, 8'd4,  8'd8,  8'd2},
    '{3'd1, 1'b1, 3'd0, 8'd5,  8'd10, 8'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] ratioSel = 3'd0;
  logic divHalf = 1'b0;
  logic [2:0] phaseSel = 3'd0;
  logic wordStrobe, lsClk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  word_timing_gen u_dut (
    .clk(clk), .rstN(rstN), .ratioSel(ratioSel), .divHalf(divHalf),
    .phaseSel(phaseSel), .wordStrobe(wordStrobe), .lsClk(lsClk)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [2:0] sel, input logic dh, input logic [2:0] ph);
    @(negedge clk);
    ratioSel = sel; divHalf = dh; phaseSel = ph;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    check(!wordStrobe && !lsClk, "R1 outputs low in reset", {wordStrobe, lsClk}, 0);
    rstN = 1'b1;
    cyc = 0;
  endtask

  // Runs until cycle 'upto'; expectations from requirements R3..R6 relative to 'base'
  task automatic runSpan(input int r, input int p, input int off, input int base,
                         input int upto, input string req);
    int badS = 0, badL = 0, firstS = -1, firstL = -1;
    int aS = 0, eS = 0, aL = 0, eL = 0;
    while (cyc < upto) begin
      int m, rel, expS, expL;
      @(negedge clk);
      cyc++;
      m = cyc - base;
      rel = (((m - off) % p) + p) % p;
      expS = (cyc > 0 && (m % r) == 0) ? 1 : 0;
      expL = (rel < p / 2) ? 1 : 0;
      if (int'(wordStrobe) != expS) begin
        badS++;
        if (firstS < 0) begin firstS = cyc; aS = int'(wordStrobe); eS = expS; end
      end
      if (int'(lsClk) != expL) begin
        badL++;
        if (firstL < 0) begin firstL = cyc; aL = int'(lsClk); eL = expL; end
      end
    end
    check(badS == 0, $sformatf("R3 strobe %s cyc %0d", req, firstS), aS, eS);
    check(badL == 0, $sformatf("R5 lsClk %s cyc %0d", req, firstL), aL, eL);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // Table walk: R2 ratio codes, R4 halving, R6 offsets, R7 rotation ignored
    for (int i = 0; i < NV; i++) begin
      doReset(VECS[i].sel, VECS[i].dh, VECS[i].ph);
      runSpan(int'(VECS[i].r), int'(VECS[i].p), int'(VECS[i].off), 0,
              3 * int'(VECS[i].p), $sformatf("R2 R4 R6 R7 vec%0d", i));
    end

    // R7: ratio 10 with largest phase code still has zero offset
    doReset(3'd3, 1'b0, 3'd7);
    runSpan(10, 10, 0, 0, 30, "R7 ratio10 ph7");

    // R8: phase change mid-period waits for boundary at cycle 8
    doReset(3'd2, 1'b0, 3'd0);
    runSpan(8, 8, 0, 0, 3, "R8 before phase change");
    phaseSel = 3'd4;
    runSpan(8, 8, 0, 0, 7, "R8 old phase holds");
    runSpan(8, 8, 4, 8, 24, "R8 new phase");

    // R8: ratio change 4 -> 8 at cycle 1 applies from cycle 4
    doReset(3'd0, 1'b0, 3'd0);
    runSpan(4, 4, 0, 0, 1, "R8 before ratio change");
    ratioSel = 3'd2;
    runSpan(4, 4, 0, 0, 3, "R8 old ratio holds");
    runSpan(8, 8, 0, 4, 28, "R8 new ratio");

    // R1: reset mid-run restarts timing from zero
    doReset(3'd4, 1'b1, 3'd2);
    runSpan(16, 32, 8, 0, 20, "R1 pre-reset");
    doReset(3'd4, 1'b1, 3'd2);
    runSpan(16, 32, 8, 0, 64, "R1 restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule